// File: doc/BRIEF.md
# Single-Wire Bus Master

This block performs the timed primitives of a single-wire bus on one open-drain data line that a resistor pulls up. Three commands are accepted: a bus reset with presence detection, the transmission of one byte, and the reception of one to eight bits. The line is only ever pulled low or released, never driven high. Every phase is measured in microseconds. A prescaler derives a 1 µs tick from the system clock, with the divide value supplied as an input.

The pad's input level reaches the sequencer through a two-flop synchronizer. A controller loads a command while `busy_o` is low, then waits for the one-cycle `done_o` pulse. After a read it collects the bits from `rd_data_o`. After a reset it checks `presence_o`. Any command presented while a primitive is in progress is dropped.

Top module: `owm_master`

## Requirements
- R1: One microsecond equals `div_i` system clocks. A `div_i` of 0 acts as 1. The microsecond count restarts from zero on the clock edge that accepts a command.
- R2: A reset command (op 0) pulls the line low for exactly 480 µs and then releases it.
- R3: `presence_o` becomes 1 when the synchronized line is low 60 µs after the reset low ends (540 µs into the reset), and 0 when the line is high. Only a reset command changes it.
- R4: A reset command completes 960 µs after acceptance.
- R5: A write command (op 1) emits 8 slots of 62 µs each. A 1 bit holds the line low for 5 µs and a 0 bit for 60 µs. The line is then released for the rest of the slot.
- R6: Write bits go out least significant bit first. The command completes after 8 slots (496 µs).
- R7: A read slot (op 2) holds the line low for 3 µs and samples the synchronized line 6 µs after the slot starts. The slot lasts 62 µs.
- R8: A read of n bits (`rd_cnt_i` from 1 to 8) clears `rd_data_o` at acceptance. The k-th bit read (k starting at 0) goes to bit k and the upper bits stay 0. The command completes after n slots. A read count of 0 or above 8 is ignored.
- R9: A command presented while `busy_o` is high is ignored.
- R10: Opcode 3 is reserved and ignored.
- R11: When idle the line is released. `done_o` is a single-cycle pulse, raised in the first cycle in which `busy_o` is low again. `rd_data_o` changes only while busy.
- R12: After reset the line is released, `busy_o` and `done_o` are 0, and `presence_o` and `rd_data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | 8 | System clocks per microsecond |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0 reset, 1 write byte, 2 read bits, 3 reserved |
| wr_byte_i | input | 8 | Byte to send on write |
| rd_cnt_i | input | 4 | Number of bits to read (1 to 8) |
| line_i | input | 1 | Pad input level (asynchronous) |
| line_drive_low_o | output | 1 | 1 pulls the line low, 0 releases it |
| busy_o | output | 1 | Primitive in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | 8 | Received bits, first bit at bit 0 |
| presence_o | output | 1 | Device answered the last reset |

## Verification
A wrong microsecond counter or a stuck phase state appears at once in the length of the next low pulse on `line_drive_low_o`. Each pulse is measured in system clocks against its exact expected width. A wrong bit index or shift shows up within one slot as a pulse of the wrong length, or as wrong bits in `rd_data_o` at the following `done_o`. A wrongly timed presence or read sample appears as a wrong `presence_o` or `rd_data_o` value at the end of that command. The bench's device model holds the line low for a window that brackets the intended sample point.

// File: rtl/owm_pkg.sv
package owm_pkg;
  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RESET,
    ST_WRITE,
    ST_READ
  } state_e;
endpackage

// File: rtl/owm_tick_gen.sv
module owm_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  // a divide of 0 behaves as 1
  assign lim    = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = !clr_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/owm_sync.sv
module owm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  // reset to released (high) level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/owm_seq.sv
module owm_seq
  import owm_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int T_RST_LOW   = 480,
  parameter int T_PRES_WAIT = 60,
  parameter int T_RST_REC   = 480,
  parameter int T_SLOT      = 62,
  parameter int T_W1_LOW    = 5,
  parameter int T_W0_LOW    = 60,
  parameter int T_RD_LOW    = 3,
  parameter int T_RD_SMP    = 6,
  localparam int CNT_W      = $clog2(BYTE_W + 1),
  localparam int IDX_W      = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_s_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  input  logic [CNT_W-1:0]  rd_cnt_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              drive_low_o,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              presence_o
);
  localparam int T_PRES_SMP = T_RST_LOW + T_PRES_WAIT;
  localparam int T_RST_END  = T_RST_LOW + T_RST_REC;
  localparam int US_W       = $clog2(T_RST_END + 1);

  state_e            st_q;
  logic [US_W-1:0]   us_q;
  logic [CNT_W-1:0]  left_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] rd_q;
  logic              pres_q;
  logic              done_q;

  op_e  op;
  logic legal;
  logic accept;
  logic last_us;

  assign op     = op_e'(cmd_op_i);
  assign legal  = (op == OP_RESET) || (op == OP_WRITE) ||
                  ((op == OP_READ) && (rd_cnt_i != '0) &&
                   (rd_cnt_i <= CNT_W'(BYTE_W)));
  assign accept = cmd_valid_i && (st_q == ST_IDLE) && legal;

  always_comb begin
    if (st_q == ST_RESET) last_us = (us_q == US_W'(T_RST_END - 1));
    else                  last_us = (us_q == US_W'(T_SLOT - 1));
  end

  always_comb begin
    unique case (st_q)
      ST_RESET: drive_low_o = (us_q < US_W'(T_RST_LOW));
      ST_WRITE: drive_low_o = sh_q[0] ? (us_q < US_W'(T_W1_LOW))
                                      : (us_q < US_W'(T_W0_LOW));
      ST_READ:  drive_low_o = (us_q < US_W'(T_RD_LOW));
      default:  drive_low_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      us_q   <= '0;
      left_q <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      rd_q   <= '0;
      pres_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (accept) begin
          us_q  <= '0;
          idx_q <= '0;
          sh_q  <= wr_byte_i;
          unique case (op)
            OP_RESET: st_q <= ST_RESET;
            OP_WRITE: begin
              st_q   <= ST_WRITE;
              left_q <= CNT_W'(BYTE_W);
            end
            default: begin
              st_q   <= ST_READ;
              left_q <= rd_cnt_i;
              rd_q   <= '0;
            end
          endcase
        end
      end else if (tick_i) begin
        if (st_q == ST_RESET && us_q == US_W'(T_PRES_SMP - 1))
          pres_q <= !line_s_i;
        if (st_q == ST_READ && us_q == US_W'(T_RD_SMP - 1))
          rd_q[idx_q] <= line_s_i;
        if (last_us) begin
          us_q <= '0;
          if (st_q == ST_RESET || left_q == CNT_W'(1)) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            left_q <= left_q - 1'b1;
            idx_q  <= idx_q + 1'b1;
            sh_q   <= sh_q >> 1;
          end
        end else begin
          us_q <= us_q + 1'b1;
        end
      end
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign rd_data_o  = rd_q;
  assign presence_o = pres_q;
endmodule

// File: rtl/owm_master.sv
module owm_master #(
  parameter int DIV_W       = 8,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int T_RST_LOW   = 480,
  parameter int T_PRES_WAIT = 60,
  parameter int T_RST_REC   = 480,
  parameter int T_SLOT      = 62,
  parameter int T_W1_LOW    = 5,
  parameter int T_W0_LOW    = 60,
  parameter int T_RD_LOW    = 3,
  parameter int T_RD_SMP    = 6,
  localparam int CNT_W      = $clog2(BYTE_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  input  logic [CNT_W-1:0]  rd_cnt_i,
  input  logic              line_i,
  output logic              line_drive_low_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              presence_o
);
  logic tick;
  logic line_s;

  owm_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!busy_o),
    .div_i  (div_i),
    .tick_o (tick)
  );

  owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (line_i),
    .q_o    (line_s)
  );

  owm_seq #(
    .BYTE_W      (BYTE_W),
    .T_RST_LOW   (T_RST_LOW),
    .T_PRES_WAIT (T_PRES_WAIT),
    .T_RST_REC   (T_RST_REC),
    .T_SLOT      (T_SLOT),
    .T_W1_LOW    (T_W1_LOW),
    .T_W0_LOW    (T_W0_LOW),
    .T_RD_LOW    (T_RD_LOW),
    .T_RD_SMP    (T_RD_SMP)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .line_s_i    (line_s),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .wr_byte_i   (wr_byte_i),
    .rd_cnt_i    (rd_cnt_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .drive_low_o (line_drive_low_o),
    .rd_data_o   (rd_data_o),
    .presence_o  (presence_o)
  );
endmodule

// File: rtl/owm_master_chk.sv
module owm_master_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              line_drive_low_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [BYTE_W-1:0] rd_data_o,
  input logic              presence_o
);
  // R11
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !line_drive_low_o);

  // R11
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  done_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  // R3
  pres_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (presence_o != $past(presence_o)) |-> $past(busy_o));

  // R8
  rd_hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> $stable(rd_data_o));
endmodule

bind owm_master owm_master_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .line_drive_low_o (line_drive_low_o),
  .busy_o           (busy_o),
  .done_o           (done_o),
  .rd_data_o        (rd_data_o),
  .presence_o       (presence_o)
);

// File: tb/owm_master_tb.sv
`timescale 1ns/1ps
module owm_master_tb;
  typedef struct {
    int         cyc;
    logic [7:0] data;
    logic       pres;
    string      req;
  } done_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div = 8'd2;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [7:0] wr_byte = '0;
  logic [3:0] rd_cnt = '0;
  logic       dev_low = 1'b0;
  logic       line;
  logic       drv_low, busy, done, pres;
  logic [7:0] rd_data;

  int    n_run = 0, n_fail = 0;
  int    lo_q[$];
  string lo_req_q[$];
  done_t dn_q[$];
  int    lo_run = 0, bz_run = 0;
  int    dev_mode = 0;
  logic  rd_pat[$];
  logic [7:0] exp_data = '0;
  logic       exp_pres = 1'b0;
  bit    finished = 1'b0;

  always #2.5 clk = ~clk;

  assign line = !(drv_low || dev_low);

  owm_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .cmd_valid_i(cmd_valid),
    .cmd_op_i(cmd_op), .wr_byte_i(wr_byte), .rd_cnt_i(rd_cnt),
    .line_i(line), .line_drive_low_o(drv_low), .busy_o(busy),
    .done_o(done), .rd_data_o(rd_data), .presence_o(pres)
  );

  function automatic int dv();
    return (div == 0) ? 1 : int'(div);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // device model: presence answer after reset low ends
  always begin
    @(negedge drv_low);
    if (dev_mode == 1) begin
      #(15 * dv() * 5);
      dev_low = 1'b1;
      #(120 * dv() * 5);
      dev_low = 1'b0;
    end
  end

  // device model: a 0 bit holds the line low for 12 us from the slot start
  always begin
    @(posedge drv_low);
    if (dev_mode == 2 && rd_pat.size() > 0) begin
      logic b;
      b = rd_pat.pop_front();
      if (!b) begin
        dev_low = 1'b1;
        #(12 * dv() * 5);
        dev_low = 1'b0;
      end
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (drv_low) lo_run++;
      else if (lo_run > 0) begin
        if (lo_q.size() == 0) check(0, "R9/R10 unexpected low pulse", lo_run, 0);
        else begin
          int e;
          string r;
          e = lo_q.pop_front();
          r = lo_req_q.pop_front();
          check(lo_run == e, r, lo_run, e);
        end
        lo_run = 0;
      end
      if (busy) bz_run++;
      if (done) begin
        if (dn_q.size() == 0) check(0, "R9 unexpected done", bz_run, 0);
        else begin
          done_t d;
          d = dn_q.pop_front();
          check(bz_run == d.cyc, {d.req, " duration"}, bz_run, d.cyc);
          check(rd_data == d.data, {d.req, " rd_data"}, rd_data, d.data);
          check(pres == d.pres, "R3 presence", pres, d.pres);
        end
        bz_run = 0;
      end
    end
  end

  task automatic pulse_cmd(input logic [1:0] op, input logic [7:0] b, input logic [3:0] n);
    @(negedge clk);
    cmd_op = op; wr_byte = b; rd_cnt = n; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset(input bit present, input string req);
    dev_mode = present ? 1 : 0;
    exp_pres = present;
    lo_q.push_back(480 * dv()); lo_req_q.push_back("R2/R1 reset low");
    dn_q.push_back('{960 * dv(), exp_data, exp_pres, req});
    pulse_cmd(2'd0, 8'h00, 4'd0);
    wait_done();
    dev_mode = 0;
  endtask

  task automatic do_write(input logic [7:0] b, input bit wait_it);
    dev_mode = 0;
    for (int i = 0; i < 8; i++) begin
      lo_q.push_back((b[i] ? 5 : 60) * dv());
      lo_req_q.push_back(b[i] ? "R5/R6 write-1 low" : "R5/R6 write-0 low");
    end
    dn_q.push_back('{8 * 62 * dv(), exp_data, exp_pres, "R6 write"});
    pulse_cmd(2'd1, b, 4'd0);
    if (wait_it) wait_done();
  endtask

  task automatic do_read(input logic [7:0] pat, input int n);
    dev_mode = 2;
    rd_pat.delete();
    exp_data = '0;
    for (int i = 0; i < n; i++) begin
      rd_pat.push_back(pat[i]);
      exp_data[i] = pat[i];
      lo_q.push_back(3 * dv()); lo_req_q.push_back("R7 read low");
    end
    dn_q.push_back('{n * 62 * dv(), exp_data, exp_pres, "R7/R8 read"});
    pulse_cmd(2'd2, 8'h00, 4'(n));
    wait_done();
    dev_mode = 0;
  endtask

  task automatic try_ignored(input logic [1:0] op, input logic [3:0] n, input string req);
    bit seen;
    seen = 0;
    pulse_cmd(op, 8'h5A, n);
    repeat (40) begin
      @(negedge clk);
      if (busy || drv_low) seen = 1;
    end
    check(!seen, req, seen, 0);
  endtask

  initial begin
    #(200000 * 5);
    check(0, "watchdog", 0, 1);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!drv_low && !busy && !done, "R12 idle outputs", {drv_low, busy, done}, 0);
    check(!pres && rd_data == 0, "R12 result outputs", {pres, rd_data}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    div = 8'd2;
    do_reset(1, "R4 reset present");
    do_reset(0, "R4 reset absent");
    do_reset(1, "R4 reset present again");
    do_write(8'hA5, 1);
    do_write(8'h0F, 1);
    do_read(8'h3C, 8);
    do_read(8'h05, 3);
    try_ignored(2'd2, 4'd0, "R8 read count 0 ignored");
    try_ignored(2'd2, 4'd9, "R8 read count 9 ignored");
    try_ignored(2'd3, 4'd4, "R10 reserved opcode ignored");

    // R9: reset request during a write is dropped
    do_write(8'hFF, 0);
    repeat (100) @(negedge clk);
    pulse_cmd(2'd0, 8'h00, 4'd0);
    wait_done();

    // R1: other divide values
    div = 8'd8;
    do_reset(0, "R1 reset div 8");
    div = 8'd0;
    do_read(8'h01, 1);
    div = 8'd3;
    do_write(8'h81, 1);

    repeat (20) @(negedge clk);
    check(lo_q.size() == 0, "R5 pending low pulses", lo_q.size(), 0);
    check(dn_q.size() == 0, "R11 pending completions", dn_q.size(), 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule